// File: doc/BRIEF.md
# Two-Stage Timebase Watchdog

This block pairs a free-running timebase counter with a watchdog that needs two expiries before it acts. Software sees it through a plain 32-bit register port with address, write strobe, write data, read strobe and read data. The watchdog is armed only while two enable bits, one in each of two control registers, are both set. Once armed, it measures intervals of 2^INTERVAL_EXP clock cycles. The first interval that ends without service sets a warning flag and raises an interrupt. The second one, which ends while that warning flag is still set, drives a system reset pulse and latches a reset-cause flag.

Software keeps the system alive by writing ones to the flag positions of control register 0. This clears the chosen flags and restarts the interval. Software can read the timebase at any time to confirm that the clock is running. With the ENABLE_ONCE parameter set, the watchdog cannot be switched off again once it has been armed. The reset-cause flag survives the reset pulse, so software can find out after a restart why the system was reset.

Top module: `tbwd_top`

## Requirements
- R1: After rst_n is released, control register 0 (byte address 0x0) and control register 1 (byte address 0x4) read as zero, and wd_irq and wd_sys_rst are low.
- R2: The timebase at byte address 0x8 advances by one on every clock, so two reads issued on consecutive cycles return values that differ by exactly one.
- R3: The watchdog is armed only when control register 0 bit 1 and control register 1 bit 0 are both 1. While disarmed, no expiry occurs and the flags hold their values.
- R4: A write to control register 0 clears the warning flag (bit 2) when data bit 2 is 1 and clears the reset-cause flag (bit 3) when data bit 3 is 1. Either of these restarts the interval from zero. Writing 0 to those bits leaves the flags unchanged.
- R5: Let E be the rising clock edge at which arming or a flag-clearing write is sampled. The warning flag sets, and is readable at bit 2, at edge E + 2^INTERVAL_EXP.
- R6: If the warning flag is still set, the next expiry (edge E + 2·2^INTERVAL_EXP) drives wd_sys_rst high for exactly RST_PULSE cycles. The same expiry sets the reset-cause flag (bit 3), which stays set until software clears it.
- R7: With ENABLE_ONCE=1, once the watchdog has been armed, writes of 0 to either enable bit are ignored. With ENABLE_ONCE=0, such writes disarm it.
- R8: wd_irq is high exactly while the warning flag is set, and it drops the cycle after the clearing write.
- R9: Reserved bits and unmapped addresses read as zero. Read data appears on bus_rdata on the cycle after the bus_rd cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the timebase, the watchdog and the register port |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe; data follows one cycle later |
| bus_rdata | output | DATA_W | Registered read data |
| wd_irq | output | 1 | Interrupt, follows the warning flag |
| wd_sys_rst | output | 1 | System reset pulse, RST_PULSE cycles long |

## Verification
An interval counter that restarts at the wrong moment moves the interrupt edge away from its cycle. The bench samples the cycle before the edge and the cycle after it, so such a shift shows within one interval. A warning flag that clears too early or never sets shows at once as a missing reset pulse one interval later, or as a wrong value at bit 2 on the next read. A lost enable or a broken lock shows on the next control-register read. A stalled timebase shows on the second of two back-to-back reads.

// File: rtl/tbwd_pkg.sv
`timescale 1ns/1ps
package tbwd_pkg;
   // byte offsets decoded by the register file
   localparam int unsigned OFS_CTRL0 = 0;
   localparam int unsigned OFS_CTRL1 = 4;
   localparam int unsigned OFS_TBASE = 8;
   // bit positions software relies on
   localparam int unsigned C0_RSTF  = 3;
   localparam int unsigned C0_STATE = 2;
   localparam int unsigned C0_EN    = 1;
   localparam int unsigned C1_EN    = 0;

   typedef enum logic [1:0] {
      SEL_NONE,
      SEL_CTRL0,
      SEL_CTRL1,
      SEL_TBASE
   } reg_sel_e;
endpackage

// File: rtl/tbwd_timebase.sv
`timescale 1ns/1ps
module tbwd_timebase #(
   parameter int unsigned TB_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [TB_W-1:0] tb_value
);
   logic [TB_W-1:0] count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count_q <= '0;
      else        count_q <= count_q + 1'b1;
   end

   assign tb_value = count_q;

   AST_TB_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (count_q != $past(count_q))); // R2
endmodule

// File: rtl/tbwd_regs.sv
`timescale 1ns/1ps
module tbwd_regs
   import tbwd_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned TB_W        = 32,
   parameter bit          ENABLE_ONCE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [TB_W-1:0]   tb_value,
   input  logic              state_flag,
   input  logic              rstf_flag,
   output logic              armed,
   output logic              clr_state,
   output logic              clr_rstf,
   output logic              kick
);
   reg_sel_e          sel;
   logic              en0_q, en1_q;
   logic              locked;
   logic              wr0, wr1;
   logic [DATA_W-1:0] rd_mux;
   logic [DATA_W-1:0] rdata_q;
   logic              unused_wdata;

   always_comb begin
      if (bus_addr == ADDR_W'(OFS_CTRL0))      sel = SEL_CTRL0;
      else if (bus_addr == ADDR_W'(OFS_CTRL1)) sel = SEL_CTRL1;
      else if (bus_addr == ADDR_W'(OFS_TBASE)) sel = SEL_TBASE;
      else                                     sel = SEL_NONE;
   end

   assign wr0 = bus_wr && (sel == SEL_CTRL0);
   assign wr1 = bus_wr && (sel == SEL_CTRL1);

   generate
      if (ENABLE_ONCE) begin : g_once
         logic lock_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lock_q <= 1'b0;
            else        lock_q <= lock_q | (en0_q & en1_q);
         end
         assign locked = lock_q;

         AST_LOCK_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
            lock_q |=> (en0_q && en1_q)); // R7
      end else begin : g_free
         assign locked = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en0_q <= 1'b0;
         en1_q <= 1'b0;
      end else begin
         if (wr0) en0_q <= bus_wdata[C0_EN] | locked;
         if (wr1) en1_q <= bus_wdata[C1_EN] | locked;
      end
   end

   assign armed     = en0_q & en1_q;
   assign clr_state = wr0 & bus_wdata[C0_STATE];
   assign clr_rstf  = wr0 & bus_wdata[C0_RSTF];
   assign kick      = clr_state | clr_rstf;

   always_comb begin
      rd_mux = '0;
      case (sel)
         SEL_CTRL0: begin
            rd_mux[C0_RSTF]  = rstf_flag;
            rd_mux[C0_STATE] = state_flag;
            rd_mux[C0_EN]    = en0_q;
         end
         SEL_CTRL1: rd_mux[C1_EN]    = en1_q;
         SEL_TBASE: rd_mux[TB_W-1:0] = tb_value;
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (bus_rd) rdata_q <= rd_mux;
   end

   assign bus_rdata    = rdata_q;
   assign unused_wdata = &{1'b0, bus_wdata};
endmodule

// File: rtl/tbwd_expiry.sv
`timescale 1ns/1ps
module tbwd_expiry #(
   parameter int unsigned INTERVAL_EXP = 16,
   parameter int unsigned RST_PULSE    = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic armed,
   input  logic kick,
   input  logic clr_state,
   input  logic clr_rstf,
   output logic state_flag,
   output logic rstf_flag,
   output logic sys_rst
);
   localparam int unsigned PW = $clog2(RST_PULSE + 1);

   logic [INTERVAL_EXP-1:0] ivl_q;
   logic                    expire;
   logic                    second;
   logic                    state_q, rstf_q;
   logic [PW-1:0]           pulse_q;

   // a service write in the same cycle wins over an expiry
   assign expire = armed & ~kick & (&ivl_q);
   assign second = expire & state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              ivl_q <= '0;
      else if (!armed || kick) ivl_q <= '0;
      else                     ivl_q <= ivl_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= 1'b0;
         rstf_q  <= 1'b0;
      end else begin
         if (clr_state)   state_q <= 1'b0;
         else if (expire) state_q <= 1'b1;
         if (clr_rstf)    rstf_q  <= 1'b0;
         else if (second) rstf_q  <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              pulse_q <= '0;
      else if (second)         pulse_q <= PW'(RST_PULSE);
      else if (pulse_q != '0)  pulse_q <= pulse_q - 1'b1;
   end

   assign state_flag = state_q;
   assign rstf_flag  = rstf_q;
   assign sys_rst    = (pulse_q != '0);

   AST_DISARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && !clr_state) |=> $stable(state_q)); // R3
   AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_state |=> !state_q); // R4
   AST_STATE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state_q) |-> $past(armed)); // R5
   AST_RST_AFTER_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sys_rst) |-> $past(state_q)); // R6
   AST_RSTF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (rstf_q && !clr_rstf) |=> rstf_q); // R6
endmodule

// File: rtl/tbwd_top.sv
`timescale 1ns/1ps
module tbwd_top #(
   parameter int unsigned ADDR_W       = 8,
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned TB_W         = 32,
   parameter int unsigned INTERVAL_EXP = 16,
   parameter int unsigned RST_PULSE    = 16,
   parameter bit          ENABLE_ONCE  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              wd_irq,
   output logic              wd_sys_rst
);
   generate
      if (ADDR_W < 4)                           $error("ADDR_W must cover offset 0x8");
      if (DATA_W < 4)                           $error("DATA_W must hold the flag bits");
      if (TB_W < 1 || TB_W > DATA_W)            $error("TB_W must fit in DATA_W");
      if (INTERVAL_EXP < 1 || INTERVAL_EXP > 31) $error("INTERVAL_EXP out of range");
      if (RST_PULSE < 1)                        $error("RST_PULSE must be at least 1");
   endgenerate

   logic [TB_W-1:0] tb_value;
   logic armed, kick, clr_state, clr_rstf;
   logic state_flag, rstf_flag;

   tbwd_timebase #(.TB_W(TB_W)) u_tb (
      .clk      (clk),
      .rst_n    (rst_n),
      .tb_value (tb_value)
   );

   tbwd_regs #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .TB_W        (TB_W),
      .ENABLE_ONCE (ENABLE_ONCE)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_addr   (bus_addr),
      .bus_wr     (bus_wr),
      .bus_wdata  (bus_wdata),
      .bus_rd     (bus_rd),
      .bus_rdata  (bus_rdata),
      .tb_value   (tb_value),
      .state_flag (state_flag),
      .rstf_flag  (rstf_flag),
      .armed      (armed),
      .clr_state  (clr_state),
      .clr_rstf   (clr_rstf),
      .kick       (kick)
   );

   tbwd_expiry #(
      .INTERVAL_EXP (INTERVAL_EXP),
      .RST_PULSE    (RST_PULSE)
   ) u_exp (
      .clk        (clk),
      .rst_n      (rst_n),
      .armed      (armed),
      .kick       (kick),
      .clr_state  (clr_state),
      .clr_rstf   (clr_rstf),
      .state_flag (state_flag),
      .rstf_flag  (rstf_flag),
      .sys_rst    (wd_sys_rst)
   );

   assign wd_irq = state_flag;

   AST_IRQ_DROPS_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr_state |=> !wd_irq); // R8
endmodule

// File: tb/tbwd_top_tb_top.sv
`timescale 1ns/1ps
module tbwd_top_tb_top;
   localparam int unsigned IEXP = 4;
   localparam int unsigned PLS  = 3;
   localparam int unsigned IV   = 1 << IEXP;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic [31:0] rdata_a, rdata_b;
   logic        irq_a, irq_b, srst_a, srst_b;

   always #2.5 clk = ~clk;

   tbwd_top #(.INTERVAL_EXP(IEXP), .RST_PULSE(PLS), .ENABLE_ONCE(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(rdata_a),
      .wd_irq(irq_a), .wd_sys_rst(srst_a));

   tbwd_top #(.INTERVAL_EXP(IEXP), .RST_PULSE(PLS), .ENABLE_ONCE(1'b1)) dut_once_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(rdata_b),
      .wd_irq(irq_b), .wd_sys_rst(srst_b));

   // kind: 0 exact compare, 1 record timebase, 2 timebase must be previous + 1
   typedef struct {
      int          which;
      int          kind;
      logic [31:0] exp;
      logic [31:0] mask;
      string       req;
   } item_t;

   item_t       sbq[$];
   int          n_cmp = 0;
   int          n_bad = 0;
   bit          done = 1'b0;
   bit          rd_q = 1'b0;
   logic [31:0] last_tb = '0;

   always @(posedge clk) rd_q <= bus_rd;

   // monitor: pops one expected item per completed read
   always @(negedge clk) begin
      if (rd_q) begin
         item_t       it;
         logic [31:0] act, want;
         if (sbq.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R9: read data with empty scoreboard, actual %h expected none", rdata_a);
         end else begin
            it  = sbq.pop_front();
            act = (it.which != 0) ? rdata_b : rdata_a;
            if (it.kind == 1) begin
               last_tb = act;
            end else begin
               want = (it.kind == 2) ? (last_tb + 32'd1) : it.exp;
               n_cmp++;
               if ((act & it.mask) !== (want & it.mask)) begin
                  n_bad++;
                  $display("FAIL %s: actual %h expected %h", it.req, act & it.mask, want & it.mask);
               end
               if (it.kind == 2) last_tb = act;
            end
         end
      end
   end

   task automatic push(input int which, input int kind, input logic [31:0] exp,
                       input logic [31:0] mask, input string req);
      item_t it;
      it.which = which; it.kind = kind; it.exp = exp; it.mask = mask; it.req = req;
      sbq.push_back(it);
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input int which, input logic [7:0] a, input logic [31:0] exp,
                           input logic [31:0] mask, input string req);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      push(which, 0, exp, mask, req);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic chk_pin(input string req, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0b expected %0b", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         summary();
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      // R1 reset state
      chk_pin("R1 irq", irq_a, 1'b0);
      chk_pin("R1 sys_rst", srst_a, 1'b0);
      bus_read(0, 8'h0, 32'h0, 32'hFFFF_FFFF, "R1 ctrl0");
      bus_read(0, 8'h4, 32'h0, 32'hFFFF_FFFF, "R1 ctrl1");

      // R2 back-to-back timebase reads
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = 8'h8;
      push(0, 1, 32'h0, 32'hFFFF_FFFF, "R2");
      @(negedge clk);
      push(0, 2, 32'h0, 32'hFFFF_FFFF, "R2 tb step");
      @(negedge clk);
      push(0, 2, 32'h0, 32'hFFFF_FFFF, "R2 tb step");
      @(negedge clk);
      bus_rd = 1'b0;

      // R3 only one enable set: no expiry
      bus_write(8'h0, 32'h2);
      idle(3 * IV);
      chk_pin("R3 half enable irq", irq_a, 1'b0);
      bus_read(0, 8'h0, 32'h2, 32'hFFFF_FFFF, "R3 ctrl0 en only");

      // arm: edge E is the ctrl1 write
      bus_write(8'h4, 32'h1);
      idle(IV - 1);
      chk_pin("R5 irq before first expiry", irq_a, 1'b0);
      idle(1);
      chk_pin("R5 irq at first expiry", irq_a, 1'b1);
      bus_read(0, 8'h0, 32'h6, 32'hFFFF_FFFF, "R5 ctrl0 state flag");

      // keepalive at edge K
      bus_write(8'h0, 32'h6);
      chk_pin("R8 irq drops on clear", irq_a, 1'b0);
      idle(IV - 1);
      chk_pin("R4 restart, irq still low", irq_a, 1'b0);
      idle(1);
      chk_pin("R4 irq one interval after kick", irq_a, 1'b1);
      chk_pin("R6 no reset after first expiry", srst_a, 1'b0);
      idle(IV - 1);
      chk_pin("R6 reset before second expiry", srst_a, 1'b0);
      idle(1);
      chk_pin("R6 reset at second expiry", srst_a, 1'b1);
      idle(PLS - 1);
      chk_pin("R6 reset last pulse cycle", srst_a, 1'b1);
      idle(1);
      chk_pin("R6 reset pulse ended", srst_a, 1'b0);
      bus_read(0, 8'h0, 32'hE, 32'hFFFF_FFFF, "R6 reset flag after pulse");

      // R4 writing zeros to the flag bits leaves them
      bus_write(8'h0, 32'h2);
      bus_read(0, 8'h0, 32'hE, 32'hFFFF_FFFF, "R4 zero write keeps flags");
      bus_write(8'h0, 32'hA);
      bus_read(0, 8'h0, 32'h6, 32'hFFFF_FFFF, "R4 clear reset flag only");
      chk_pin("R8 irq still high", irq_a, 1'b1);
      bus_write(8'h0, 32'h6);
      bus_read(0, 8'h0, 32'h2, 32'hFFFF_FFFF, "R4 clear state flag");

      // R7 disarm: free instance stops, locked instance stays armed
      bus_write(8'h0, 32'h0);
      bus_read(0, 8'h0, 32'h0, 32'hFFFF_FFFF, "R7 free ctrl0 disabled");
      bus_read(1, 8'h0, 32'h2, 32'h2, "R7 locked ctrl0 enable kept");
      idle(3 * IV);
      chk_pin("R3 disarmed irq", irq_a, 1'b0);
      chk_pin("R3 disarmed sys_rst", srst_a, 1'b0);
      bus_read(0, 8'h0, 32'h0, 32'hFFFF_FFFF, "R3 disarmed flags");

      // R9 reserved bits and unmapped address
      bus_write(8'h4, 32'hFFFF_FFFE);
      bus_read(0, 8'h4, 32'h0, 32'hFFFF_FFFF, "R9 ctrl1 reserved zero");
      bus_read(1, 8'h4, 32'h1, 32'h1, "R7 locked ctrl1 enable kept");
      bus_write(8'h0, 32'hFFFF_FFF2);
      bus_read(0, 8'h0, 32'h2, 32'hFFFF_FFFF, "R9 ctrl0 reserved zero");
      bus_read(0, 8'hC, 32'h0, 32'hFFFF_FFFF, "R9 unmapped address");

      idle(4);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule